// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address that a synchronous memory core reads or writes on each beat of a four-beat burst. A new access is opened by one of two active-low strobes: one comes from the processor and one from the cache controller. When a strobe is accepted, the full input address is captured. The upper bits are then held for the whole burst. The low two bits seed a wraparound beat counter, and an advance request moves that counter on by one beat per clock.

A build-time parameter picks the beat order. The interleaved order (`ORDER = 0`) XORs the start offset with the beat number, so the sequence depends on where the burst starts. The linear order (`ORDER = 1`) adds the beat number to the start offset modulo four. The chip select gates the processor strobe. When the chip select is high and the controller strobe is low, the block is deselected and the address is frozen.

Top module: `burst_addr_seq`

## Requirements
- R1: When `rst` is high at a rising clock edge, the address register and the beat counter clear, so `word_addr` reads 0 after that edge.
- R2: At a rising edge with `cs_n` low and `pstrb_n` or `cstrb_n` low, `word_addr` takes the value of `addr_in` after that edge (beat 0 of a new burst).
- R3: `pstrb_n` has no effect while `cs_n` is high; if both strobes are low while `cs_n` is low, the processor strobe is the accepted one.
- R4: At a rising edge with `cs_n` high and `cstrb_n` low, the block is deselected: `word_addr` keeps its value, and `adv_n` is ignored.
- R5: With `ORDER = 0`, the two low bits of `word_addr` after k accepted advances equal the start offset XOR k (for example, start 10 gives 10, 11, 00, 01).
- R6: With `ORDER = 1`, the two low bits after k accepted advances equal (start offset + k) mod 4 (for example, start 11 gives 11, 00, 01, 10).
- R7: The fourth accepted advance returns the low bits to the start offset, and the sequence repeats.
- R8: Bits `ADDR_W-1:2` of `word_addr` change only at an edge where a strobe is accepted or reset is applied.
- R9: An advance request in the same cycle as an accepted strobe is ignored: the new burst starts at beat 0.
- R10: When no strobe is accepted and `adv_n` is high, `word_addr` stays the same as in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance request, active low |
| addr_in | input | ADDR_W | Start address offered with a strobe |
| word_addr | output | ADDR_W | Current word address to the memory core |

## Verification
The bench runs an interleaved instance and a linear instance side by side, and compares both with a behavioural model on every clock.

- **Start offsets and wrap.** It starts bursts at all four offsets and advances past the fourth beat. A counter that ignored the start offset in interleaved mode, or that saturated instead of wrapping, would produce a wrong low address.
- **Advance during a strobe.** It pulses advance in the same cycle as a strobe. A design that let the advance through would begin the burst at beat 1.
- **Strobes with chip select high.** It drives the processor strobe with chip select high, which must act as a plain advance. It drives the controller strobe with chip select high, which must freeze the address. A design that reversed this gating would either reload the address or drift while it should be deselected.
- **Input address moving mid-burst.** The input address keeps changing during bursts. Upper bits that followed `addr_in` outside an accepted strobe would show up as a mismatch.

// File: rtl/bas_pkg.sv
package bas_pkg;

  // Which event the strobe decoder recognised this cycle
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,  // no strobe taken: hold or advance
    SRC_PROC  = 2'd1,  // processor strobe accepted
    SRC_CTRL  = 2'd2,  // controller strobe accepted
    SRC_DESEL = 2'd3   // controller strobe with chip select high
  } src_e;

  localparam int ORD_INTERLEAVE = 0;
  localparam int ORD_LINEAR     = 1;

endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
  import bas_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic pstrb_n,
  input  logic cstrb_n,
  input  logic adv_n,
  output src_e src,
  output logic load,
  output logic step
);

  // Processor strobe first, then controller strobe, then deselect
  always_comb begin
    src = SRC_IDLE;
    if (!cs_n && !pstrb_n)      src = SRC_PROC;
    else if (!cs_n && !cstrb_n) src = SRC_CTRL;
    else if (cs_n && !cstrb_n)  src = SRC_DESEL;
  end

  assign load = (src == SRC_PROC) || (src == SRC_CTRL);
  assign step = (src == SRC_IDLE) && !adv_n;

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (src != SRC_PROC && !load)); // R3

  AST_PROC_WINS: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !pstrb_n && !cstrb_n) |-> (src == SRC_PROC)); // R3

  AST_DESEL_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !cstrb_n) |-> (!step && !load)); // R4

endmodule

// File: rtl/bas_upper_reg.sv
module bas_upper_reg #(
  parameter int HI_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (rst)       hi_q <= '0;
    else if (load) hi_q <= hi_in;
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hi_q)); // R8

  AST_UPPER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (hi_q == $past(hi_in))); // R2

endmodule

// File: rtl/bas_beat_seq.sv
module bas_beat_seq #(
  parameter int CNT_W = 2,
  parameter int ORDER = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] start_in,
  output logic [CNT_W-1:0] low
);

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;

  // Interleaved order: start offset XOR beat number
  function automatic logic [CNT_W-1:0] ilv_low(input logic [CNT_W-1:0] s,
                                               input logic [CNT_W-1:0] b);
    return s ^ b;
  endfunction

  // Linear order: start offset plus beat number, wrapping
  function automatic logic [CNT_W-1:0] lin_low(input logic [CNT_W-1:0] s,
                                               input logic [CNT_W-1:0] b);
    return CNT_W'(s + b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
    end else if (step) begin
      beat_q  <= CNT_W'(beat_q + 1'b1);
    end
  end

  generate
    if (ORDER == bas_pkg::ORD_LINEAR) begin : g_linear
      assign low = lin_low(start_q, beat_q);
    end else begin : g_interleave
      assign low = ilv_low(start_q, beat_q);
    end
  endgenerate

  AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0 && low == $past(start_in))); // R9

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    step |=> (beat_q == CNT_W'($past(beat_q) + 1'b1))); // R5

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && beat_q == '1) |=> (beat_q == '0 && low == start_q)); // R7

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(low)); // R10

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int ORDER     = ORD_INTERLEAVE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int CNT_W = $clog2(BURST_LEN);
  localparam int HI_W  = ADDR_W - CNT_W;

  src_e            src;
  logic            load;
  logic            step;
  logic [HI_W-1:0] hi_q;
  logic [CNT_W-1:0] low;

  bas_strobe_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .pstrb_n (pstrb_n),
    .cstrb_n (cstrb_n),
    .adv_n   (adv_n),
    .src     (src),
    .load    (load),
    .step    (step)
  );

  bas_upper_reg #(.HI_W(HI_W)) u_hi (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .hi_in (addr_in[ADDR_W-1:CNT_W]),
    .hi_q  (hi_q)
  );

  bas_beat_seq #(.CNT_W(CNT_W), .ORDER(ORDER)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .start_in (addr_in[CNT_W-1:0]),
    .low      (low)
  );

  assign word_addr = {hi_q, low};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && (!pstrb_n || !cstrb_n)) |=> (word_addr == $past(addr_in))); // R2

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DESEL) |=> $stable(word_addr)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_IDLE && adv_n) |=> $stable(word_addr)); // R10

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          pstrb_n = 1'b1;
  logic          cstrb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_ilv;
  logic [AW-1:0] word_lin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model state
  int m_hi = 0;
  int m_st = 0;
  int m_bt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4), .ORDER(0)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
    .adv_n(adv_n), .addr_in(addr_in), .word_addr(word_ilv)
  );

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4), .ORDER(1)) uut_lin (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
    .adv_n(adv_n), .addr_in(addr_in), .word_addr(word_lin)
  );

  task automatic compare(input string tag);
    int exp_i;
    int exp_l;
    int b1;
    int b0;
    string tag_l;
    // interleaved: each low bit flips where the beat number has a one
    b1 = ((m_st / 2) + (m_bt / 2)) % 2;
    b0 = ((m_st % 2) + (m_bt % 2)) % 2;
    exp_i = m_hi * 4 + b1 * 2 + b0;
    exp_l = m_hi * 4 + ((m_st + m_bt) % 4);
    tag_l = (tag == "R5") ? "R6" : tag;
    checks++;
    if (int'(word_ilv) != exp_i) begin
      fails++;
      $display("FAIL %s interleaved: word_addr=%h expected=%h", tag, word_ilv, exp_i[AW-1:0]);
    end
    checks++;
    if (int'(word_lin) != exp_l) begin
      fails++;
      $display("FAIL %s linear: word_addr=%h expected=%h", tag_l, word_lin, exp_l[AW-1:0]);
    end
  endtask

  // One clock: drive at the falling edge, model the rising edge, check at the next falling edge
  task automatic cyc(input bit r, input bit c, input bit p, input bit k, input bit a,
                     input logic [AW-1:0] ad, input string tag);
    rst = r; cs_n = c; pstrb_n = p; cstrb_n = k; adv_n = a; addr_in = ad;
    if (r) begin
      m_hi = 0; m_st = 0; m_bt = 0;
    end else if (!c && (!p || !k)) begin
      m_hi = int'(ad) / 4; m_st = int'(ad) % 4; m_bt = 0;
    end else if (c && !k) begin
      // deselected: nothing moves
    end else if (!a) begin
      m_bt = (m_bt + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cyc(1, 1, 1, 1, 1, 16'hFFFF, "R1");
    cyc(1, 0, 0, 0, 0, 16'hABCD, "R1");

    // R2: processor strobe load, then a full burst with wrap (R5/R6, R7)
    cyc(0, 0, 0, 1, 1, 16'h1236, "R2");
    cyc(0, 0, 1, 1, 0, 16'h0000, "R5");
    cyc(0, 0, 1, 1, 0, 16'hFFFF, "R5");
    cyc(0, 0, 1, 1, 0, 16'h5555, "R5");
    cyc(0, 0, 1, 1, 0, 16'hAAAA, "R7");
    cyc(0, 0, 1, 1, 0, 16'h0F0F, "R7");

    // R10: idle hold while the input address moves
    cyc(0, 0, 1, 1, 1, 16'h9999, "R10");
    cyc(0, 1, 1, 1, 1, 16'h7777, "R10");

    // Every start offset, both orders, with idle gaps (R5, R6, R8)
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 1, 0, 1, 16'(16'h4C40 + s), "R2");
      for (int b = 0; b < 5; b++) begin
        cyc(0, 0, 1, 1, 0, 16'(16'h0100 * b), "R5");
        cyc(0, 1, 1, 1, 1, 16'hFFFC, "R8");
      end
    end

    // R9: advance together with an accepted strobe
    cyc(0, 0, 0, 1, 0, 16'h2223, "R9");
    cyc(0, 0, 1, 0, 0, 16'h3332, "R9");
    cyc(0, 0, 1, 1, 0, 16'h0000, "R9");

    // R3: both strobes low, processor wins (load of addr_in)
    cyc(0, 0, 0, 0, 1, 16'h8881, "R3");
    // R3: processor strobe with chip select high acts as a plain advance
    cyc(0, 1, 0, 1, 0, 16'h1110, "R3");
    cyc(0, 1, 0, 1, 1, 16'h1110, "R3");

    // R4: controller strobe with chip select high freezes, advance ignored
    cyc(0, 1, 1, 0, 0, 16'h6662, "R4");
    cyc(0, 1, 0, 0, 0, 16'h6663, "R4");

    // R1: reset in mid-burst
    cyc(0, 0, 1, 1, 0, 16'h0000, "R5");
    cyc(1, 0, 1, 1, 0, 16'h0000, "R1");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra;
      bit rc, rp, rk, rv;
      ra = 16'($urandom);
      rc = ($urandom % 4) == 0;
      rp = ($urandom % 5) != 0;
      rk = ($urandom % 5) != 0;
      rv = ($urandom % 3) == 0;
      cyc(0, rc, rp, rk, rv, ra, "R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule